// File: doc/BRIEF.md
# Serial FPGA Configuration Streamer

This block pushes a configuration image out of a byte-wide memory and into the slave-serial configuration pins of a target FPGA. A run begins when `start_i` is pulsed while the block is idle. The block first drops the active-low program line for a run-time number of cycles and then releases it. After that it streams the image one bit per configuration clock pulse, most significant bit of each byte first. The configuration clock is derived from the system clock by a fixed divider. The next byte is prefetched from memory while the current byte shifts, so the clock has no gaps between bytes.

There are three ways to start a run. Normal mode sends bytes in ascending address order from any start address. Swap mode reorders the bytes inside each 32-bit word by fetching byte index i from `base + (i XOR 3)`, and it refuses to stream from a start address that is not word-aligned. Legacy mode first reads and checks an eight-byte header. It then streams a fixed-length image in swap order and ignores the requested length. The block reports `busy_o` while a run is in progress and pulses `done_o` when the run ends, whether the image was streamed or rejected.

Top module: `cfg_serial_loader`

## Requirements
- R1: After an accepted start, `prog_n_o` is low for exactly the latched delay in system cycles, where a delay of 0 counts as 1. It is high again before the first rising edge of `cfg_clk_o`, and it is never low while `cfg_clk_o` is high.
- R2: Each byte leaves on `cfg_data_o` from bit 7 down to bit 0. The data value is set at least one system cycle before each rising edge of `cfg_clk_o` and holds for as long as the clock stays high.
- R3: In normal mode (`swap_i`=0, `legacy_i`=0), the block makes exactly 8×length rising clock edges and sends bytes from `base`, `base+1` and onward in ascending order, for any start address. A length of 0 gives a program pulse and no clock edges.
- R4: In swap mode (`swap_i`=1), byte index i of the stream is read from address `base + (i XOR 3)`, which gives the order 3,2,1,0,7,6,5,4 and so on. This holds for lengths that are not a multiple of four.
- R5: In swap mode with `base[1:0]` not zero, the block still makes the program pulse, then makes no clock edge and ends with `done_o`.
- R6: In legacy mode (`legacy_i`=1), the bytes at `base..base+7` must read FF FF FF FF 66 55 99 AA. These are the little-endian 32-bit words 0xFFFFFFFF and 0xAA995566. On any mismatch, the block makes no program pulse and no clock edge, and it ends with `done_o`.
- R7: In legacy mode with a valid header, the block streams LEGACY_WORDS×4 bytes in swap order starting at `base`, and the value on `len_i` has no effect.
- R8: Within a run, consecutive rising edges of `cfg_clk_o` are exactly CLK_DIV system cycles apart, including across byte boundaries.
- R9: A `start_i` pulse while `busy_o` is high has no effect on the run in progress or on its parameters.
- R10: `busy_o` is high from the cycle after an accepted start until the cycle after `done_o`. `done_o` is high for one cycle, directly after the last falling clock edge. While idle, `prog_n_o`=1, `cfg_clk_o`=0 and `done_o`=0.
- R11: The memory port returns `mem_rdata_i` one cycle after `mem_rd_o`. During streaming the block has at most one read outstanding, and the byte it fetches is ready in the prefetch buffer two cycles after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| swap_i | input | 1 | Reverse byte order within each 32-bit word |
| legacy_i | input | 1 | Check header, then stream fixed-length image in swap order |
| base_i | input | ADDR_W | Byte address of the first image byte |
| len_i | input | LEN_W | Image length in bytes (normal and swap modes) |
| prog_dly_i | input | DLY_W | Program-low duration in system cycles |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the strobe |
| prog_n_o | output | 1 | Active-low program line to the target |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| cfg_data_o | output | 1 | Serial configuration data to the target |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Most internal faults show up as a wrong serial byte. A shifter whose bit counter or load timing is off corrupts the byte value sampled at the very first rising clock edge. A fetch index that is off by one or skips the XOR shows up on the first byte boundary, within 8×CLK_DIV cycles. A late prefetch shows up as a rising-edge interval longer than CLK_DIV. A wrong program counter or header comparison shows up before any data moves, either as a program-low width that differs from the latched delay or as clock activity after a bad header. A sequencer that exits too early or too late changes the edge count and shifts the cycle in which `done_o` appears.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PROG,
    ST_STREAM,
    ST_DONE
  } ld_state_e;

  localparam logic [31:0] HDR_WORD_A = 32'hFFFF_FFFF;
  localparam logic [31:0] HDR_WORD_B = 32'hAA99_5566;

  // Expected header byte k (0..7), words stored little-endian in memory
  function automatic logic [7:0] hdr_byte(input logic [2:0] k);
    logic [31:0] w;
    w = k[2] ? HDR_WORD_B : HDR_WORD_A;
    return w[{k[1:0], 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/cfg_bit_timer.sv
module cfg_bit_timer #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cfg_clk,
  output logic tick_end
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(DIV / 2);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run)                ph_d = '0;
    else if (ph_q == PH_LAST) ph_d = '0;
    else                     ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign cfg_clk  = run && (ph_q >= PH_HIGH);
  assign tick_end = run && (ph_q == PH_LAST);

  // Rising edges only after a full low half: a new run starts low
  assert_start_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> !cfg_clk);
  assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_end |=> !tick_end);

endmodule

// File: rtl/cfg_fetch_unit.sv
module cfg_fetch_unit #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              active,
  input  logic              rev,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              take,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pf_valid,
  output logic [7:0]        pf_data,
  output logic              empty
);
  logic [LEN_W-1:0] fidx_q, fidx_d;
  logic             pend_q, pend_d;
  logic             pfv_q, pfv_d;
  logic [7:0]       pf_q, pf_d;
  logic [LEN_W-1:0] idx_x;

  assign idx_x    = rev ? (fidx_q ^ LEN_W'(3)) : fidx_q;
  assign mem_addr = base + ADDR_W'(idx_x);
  assign mem_rd   = active && !pfv_q && !pend_q && (fidx_q < len);

  always_comb begin
    fidx_d = fidx_q;
    pend_d = mem_rd;
    pfv_d  = pfv_q;
    pf_d   = pf_q;
    if (clr) begin
      fidx_d = '0;
      pfv_d  = 1'b0;
    end else begin
      if (mem_rd) fidx_d = fidx_q + 1'b1;
      if (pend_q) begin
        pfv_d = 1'b1;
        pf_d  = mem_rdata;
      end else if (take) begin
        pfv_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fidx_q <= '0;
      pend_q <= 1'b0;
      pfv_q  <= 1'b0;
      pf_q   <= '0;
    end else begin
      fidx_q <= fidx_d;
      pend_q <= pend_d;
      pfv_q  <= pfv_d;
      pf_q   <= pf_d;
    end
  end

  assign pf_valid = pfv_q;
  assign pf_data  = pf_q;
  assign empty    = (fidx_q == len) && !pfv_q && !pend_q;

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  assert_fill_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ##2 pf_valid);

endmodule

// File: rtl/cfg_shift_unit.sv
module cfg_shift_unit #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_end,
  input  logic              pf_valid,
  input  logic [BYTE_W-1:0] pf_data,
  output logic              take,
  output logic              active,
  output logic              bit_o,
  output logic              byte_end
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic              act_q, act_d;

  assign byte_end = tick_end && (bc_q == BC_LAST);
  assign take     = pf_valid && (!act_q || byte_end);

  always_comb begin
    sr_d  = sr_q;
    bc_d  = bc_q;
    act_d = act_q;
    if (take) begin
      sr_d  = pf_data;
      bc_d  = '0;
      act_d = 1'b1;
    end else if (byte_end) begin
      act_d = 1'b0;
    end else if (tick_end) begin
      sr_d = {sr_q[BYTE_W-2:0], 1'b0};
      bc_d = bc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bc_q  <= '0;
      act_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      bc_q  <= bc_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
  assign bit_o  = sr_q[BYTE_W-1];

  assert_tick_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_end |-> act_q);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int LEN_W        = 16,
  parameter int DLY_W        = 16,
  parameter int CLK_DIV      = 2,
  parameter int LEGACY_WORDS = 10524
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              swap_i,
  input  logic              legacy_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DLY_W-1:0]  prog_dly_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              prog_n_o,
  output logic              cfg_clk_o,
  output logic              cfg_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = (DLY_W > 4) ? DLY_W : 4;
  localparam logic [LEN_W-1:0] LEGACY_LEN = LEN_W'(LEGACY_WORDS * 4);
  localparam logic [CNT_W-1:0] HDR_END    = CNT_W'(8);

  ld_state_e         state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic              rev_q, rev_d;
  logic              legacy_q, legacy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              hbad_q, hbad_d;

  logic [CNT_W:0]    cnt_inc, dly_x;
  logic [CNT_W-1:0]  hk;
  logic              hdr_rd, bad_now;

  logic              f_rd, f_pfv, f_empty, take;
  logic [ADDR_W-1:0] f_addr;
  logic [7:0]        f_pf;
  logic              sh_act, sh_bit, byte_end, tick_end, clk_int;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign dly_x   = {1'b0, CNT_W'(dly_q)};
  assign hk      = cnt_q - 1'b1;
  assign bad_now = (cnt_q != '0) && (mem_rdata_i != hdr_byte(hk[2:0]));

  always_comb begin
    state_d  = state_q;
    base_d   = base_q;
    len_d    = len_q;
    dly_d    = dly_q;
    rev_d    = rev_q;
    legacy_d = legacy_q;
    cnt_d    = cnt_q;
    hbad_d   = hbad_q;
    hdr_rd   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          base_d   = base_i;
          rev_d    = swap_i || legacy_i;
          legacy_d = legacy_i;
          len_d    = legacy_i ? LEGACY_LEN : len_i;
          dly_d    = prog_dly_i;
          cnt_d    = '0;
          hbad_d   = 1'b0;
          state_d  = legacy_i ? ST_HDR : ST_PROG;
        end
      end
      ST_HDR: begin
        hdr_rd = (cnt_q < HDR_END);
        if (bad_now) hbad_d = 1'b1;
        if (cnt_q == HDR_END) begin
          cnt_d   = '0;
          state_d = (hbad_q || bad_now) ? ST_DONE : ST_PROG;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (cnt_inc >= dly_x) begin
          cnt_d = '0;
          if ((rev_q && (base_q[1:0] != 2'b00)) || (len_q == '0))
            state_d = ST_DONE;
          else
            state_d = ST_STREAM;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STREAM: begin
        if (byte_end && !take && f_empty) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      len_q    <= '0;
      dly_q    <= '0;
      rev_q    <= 1'b0;
      legacy_q <= 1'b0;
      cnt_q    <= '0;
      hbad_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      base_q   <= base_d;
      len_q    <= len_d;
      dly_q    <= dly_d;
      rev_q    <= rev_d;
      legacy_q <= legacy_d;
      cnt_q    <= cnt_d;
      hbad_q   <= hbad_d;
    end
  end

  cfg_fetch_unit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (state_q == ST_PROG),
    .active    (state_q == ST_STREAM),
    .rev       (rev_q),
    .base      (base_q),
    .len       (len_q),
    .take      (take),
    .mem_rd    (f_rd),
    .mem_addr  (f_addr),
    .mem_rdata (mem_rdata_i),
    .pf_valid  (f_pfv),
    .pf_data   (f_pf),
    .empty     (f_empty)
  );

  cfg_shift_unit #(.BYTE_W(8)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_end (tick_end),
    .pf_valid (f_pfv),
    .pf_data  (f_pf),
    .take     (take),
    .active   (sh_act),
    .bit_o    (sh_bit),
    .byte_end (byte_end)
  );

  cfg_bit_timer #(.DIV(CLK_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sh_act),
    .cfg_clk  (clk_int),
    .tick_end (tick_end)
  );

  assign mem_rd_o   = hdr_rd || f_rd;
  assign mem_addr_o = hdr_rd ? (base_q + ADDR_W'(cnt_q[2:0])) : f_addr;
  assign prog_n_o   = (state_q != ST_PROG);
  assign cfg_clk_o  = clk_int;
  assign cfg_data_o = sh_act && sh_bit;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  assert_prog_no_clk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> !cfg_clk_o);
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_o |-> $stable(cfg_data_o));
  assert_swap_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_o && rev_q) |-> (base_q[1:0] == 2'b00));
  assert_header_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_n_o && legacy_q) |-> !hbad_q);
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(base_q) && $stable(len_q) && $stable(rev_q)));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (prog_n_o && !cfg_clk_o && !done_o));

endmodule

// File: tb/cfg_serial_loader_test.sv
`timescale 1ns/1ps
module cfg_serial_loader_test;
  localparam int DIV = 2;
  localparam int LWORDS = 4;

  logic clk, rst_n, start_i, swap_i, legacy_i;
  logic [7:0] base_i, len_i, prog_dly_i, mem_addr_o, mem_rdata_i;
  logic mem_rd_o, prog_n_o, cfg_clk_o, cfg_data_o, busy_o, done_o;

  cfg_serial_loader #(.ADDR_W(8), .LEN_W(8), .DLY_W(8), .CLK_DIV(DIV),
                      .LEGACY_WORDS(LWORDS)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .swap_i(swap_i),
    .legacy_i(legacy_i), .base_i(base_i), .len_i(len_i),
    .prog_dly_i(prog_dly_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .prog_n_o(prog_n_o), .cfg_clk_o(cfg_clk_o),
    .cfg_data_o(cfg_data_o), .busy_o(busy_o), .done_o(done_o));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] mem [256];
  always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];

  int total = 0, fail = 0;
  int cyc = 0, prog_cnt = 0, done_cnt = 0, nbits = 0;
  int gap_err = 0, stab_err = 0, last_rise = 0;
  bit have_rise = 0, clk_prev = 0, held = 0;
  logic [7:0] cap [64];

  // Monitor of the serial pins, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!prog_n_o) prog_cnt++;
    if (done_o) done_cnt++;
    if (cfg_clk_o && !clk_prev) begin
      if (nbits < 512) cap[nbits/8] = {cap[nbits/8][6:0], cfg_data_o};
      nbits++;
      held = cfg_data_o;
      if (have_rise && (cyc - last_rise) != DIV) gap_err++;
      have_rise = 1;
      last_rise = cyc;
    end else if (cfg_clk_o && cfg_data_o != held) begin
      stab_err++;
    end
    clk_prev = cfg_clk_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    prog_cnt = 0; done_cnt = 0; nbits = 0; gap_err = 0; stab_err = 0;
    have_rise = 0; clk_prev = 0;
    for (int i = 0; i < 64; i++) cap[i] = '0;
  endtask

  task automatic pulse_start(input bit sw, input bit lg, input [7:0] b,
                             input [7:0] l, input [7:0] d);
    @(negedge clk);
    start_i = 1; swap_i = sw; legacy_i = lg; base_i = b; len_i = l; prog_dly_i = d;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done();
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_bytes(input string tag, input [7:0] b, input int n, input bit rev);
    int bad = 0, fa = 0, fe = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = mem[8'(b + 8'(rev ? (i ^ 3) : i))];
      if (cap[i] != e && bad == 0) begin fa = cap[i]; fe = e; end
      if (cap[i] != e) bad++;
    end
    check(bad == 0, tag, fa, fe);
  endtask

  // {swap[24], base[23:16], len[15:8], dly[7:0]}
  localparam logic [31:0] VEC [5] = '{
    32'h0010_0503, 32'h0013_0300, 32'h0120_0802,
    32'h0140_0604, 32'h0030_0002 };

  initial begin
    repeat (150000) @(posedge clk);
    total++; fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'(a * 37 + 11);
    mem[8'h80] = 8'hFF; mem[8'h81] = 8'hFF; mem[8'h82] = 8'hFF; mem[8'h83] = 8'hFF;
    mem[8'h84] = 8'h66; mem[8'h85] = 8'h55; mem[8'h86] = 8'h99; mem[8'h87] = 8'hAA;
    rst_n = 0; start_i = 0; swap_i = 0; legacy_i = 0;
    base_i = 0; len_i = 0; prog_dly_i = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(prog_n_o && !cfg_clk_o && !busy_o && !done_o, "R10 reset",
          {prog_n_o, cfg_clk_o, busy_o, done_o}, 4'b1000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      logic sw; logic [7:0] b, l, d;
      int ep;
      sw = VEC[v][24]; b = VEC[v][23:16]; l = VEC[v][15:8]; d = VEC[v][7:0];
      ep = (d == 0) ? 1 : int'(d);
      clear_mon();
      pulse_start(sw, 1'b0, b, l, d);
      wait_done();
      check(prog_cnt == ep, "R1 program width", prog_cnt, ep);
      check(nbits == 8 * l, sw ? "R4 edge count" : "R3 edge count", nbits, 8 * l);
      cmp_bytes(sw ? "R4 swap order" : "R3/R2/R11 byte order", b, l, sw);
      check(gap_err == 0, "R8 edge spacing", gap_err, 0);
      check(stab_err == 0, "R2 data hold", stab_err, 0);
      check(done_cnt == 1 && !busy_o, "R10 done pulse", done_cnt, 1);
    end

    // R5 misaligned swap
    clear_mon();
    pulse_start(1'b1, 1'b0, 8'h21, 8'd4, 8'd3);
    wait_done();
    check(prog_cnt == 3, "R5 program pulse", prog_cnt, 3);
    check(nbits == 0, "R5 no clocks", nbits, 0);
    check(done_cnt == 1, "R5 done", done_cnt, 1);

    // R6 bad header
    clear_mon();
    pulse_start(1'b0, 1'b1, 8'hA0, 8'd4, 8'd3);
    wait_done();
    check(prog_cnt == 0, "R6 no program pulse", prog_cnt, 0);
    check(nbits == 0, "R6 no clocks", nbits, 0);
    check(done_cnt == 1, "R6 done", done_cnt, 1);

    // R7 good header, len_i ignored
    clear_mon();
    pulse_start(1'b0, 1'b1, 8'h80, 8'd3, 8'd2);
    wait_done();
    check(prog_cnt == 2, "R7 program pulse", prog_cnt, 2);
    check(nbits == 8 * LWORDS * 4, "R7 fixed length", nbits, 8 * LWORDS * 4);
    cmp_bytes("R7 legacy order", 8'h80, LWORDS * 4, 1'b1);
    check(cap[4] == 8'hAA, "R7 sync byte", cap[4], 8'hAA);

    // R9 start while busy
    clear_mon();
    pulse_start(1'b0, 1'b0, 8'h10, 8'd4, 8'd2);
    check(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    repeat (20) @(negedge clk);
    start_i = 1; swap_i = 1; base_i = 8'h40; len_i = 8'd9; prog_dly_i = 8'd7;
    @(negedge clk);
    start_i = 0;
    wait_done();
    check(nbits == 32, "R9 length kept", nbits, 32);
    cmp_bytes("R9 data kept", 8'h10, 4, 1'b0);
    check(done_cnt == 1, "R9 single done", done_cnt, 1);
    check(!busy_o && prog_n_o && !cfg_clk_o, "R10 idle after run",
          {busy_o, prog_n_o, cfg_clk_o}, 3'b010);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fail);
    $finish;
  end

endmodule